// File: doc/BRIEF.md
# Threshold-Qualified Duration Event Counter

This block counts long-latency events, for example cache misses, and in its qualifying mode counts only those that last longer than a programmable limit. Each event is framed by a one-cycle start strobe and a one-cycle end strobe. The block measures how many clock cycles lie between the two strobes. It compares that duration with a 6-bit raw threshold that is multiplied by 2 or by 32, as a select bit chooses. Only an event that is strictly longer than the scaled limit increments the 32-bit event count.

When the qualify input is low, the block acts as a plain event counter: every completed event counts, whatever its duration. A count enable decides whether completed events count at all. A freeze input holds the counter. Only one event is timed at a time. The duration timer saturates, so an event of any length still compares as long.

Top module: `thr_dur_counter`

## Requirements
- R1: Asserting `rst_n` low clears the event count to 0 at once and abandons any event being timed, so an end strobe that arrives after reset release, with no new start strobe, does not count.
- R2: Duration is the number of rising clock edges from the edge that samples `evt_start` to the edge that samples `evt_end`, so a start followed by an end on the very next edge has duration 1. With `qualify` = 1, an event counts only if its duration is strictly greater than the scaled threshold.
- R3: An event whose duration equals the scaled threshold is not counted.
- R4: With `mult_sel` = 0 the scaled threshold is `thr` × 2. With `mult_sel` = 1 it is `thr` × 32.
- R5: With `qualify` = 0, every completed event increments the count by one, whatever its duration and whatever `thr` holds.
- R6: The count changes on the clock edge after the edge that samples `evt_end`, and not on the end edge itself.
- R7: The duration timer stops at its maximum value (4095 cycles with the default parameters), so an event longer than that still counts against the largest scaled threshold (2016).
- R8: While `freeze` is high the count holds its value. An event whose end strobe is sampled while `freeze` is high is dropped. An increment that falls on an edge where `freeze` is high is lost.
- R9: A start strobe that arrives while an event is being timed is ignored and does not restart the timer.
- R10: An event whose end strobe is sampled while `count_en` is low is not counted.
- R11: The count wraps from all ones to zero.
- R12: An end strobe that arrives while no event is being timed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_start | input | 1 | One-cycle strobe that marks the start of an event |
| evt_end | input | 1 | One-cycle strobe that marks the end of the event being timed |
| thr | input | 6 | Raw duration threshold |
| mult_sel | input | 1 | Threshold multiplier: 0 selects ×2, 1 selects ×32 |
| qualify | input | 1 | 1 = count only events longer than the threshold; 0 = count every event |
| count_en | input | 1 | Allows completed events to count |
| freeze | input | 1 | Holds the counter and drops events that complete |
| count | output | 32 | Event count |

## Verification
The main function is driven with durations that sit exactly on the scaled limit and one cycle past it, under both multipliers. This shows whether the comparison is strict and whether the right scale factor is applied. A duration of 1 against a zero threshold, and a very long event against the largest threshold, probe the two ends of the timer range: the second one tells a saturating timer from one that wraps. A second start strobe placed inside an event gives a total duration that counts and a restarted duration that would not, so a timer that restarts is caught. Freeze is applied once on the end edge and once on the increment edge alone, which separates an event that is dropped from an increment that is held off.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_BUSY = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/tdc_rst_sync.sv
module tdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/tdc_timer.sv
module tdc_timer
  import tdc_pkg::*;
#(
  parameter int DUR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_start,
  input  logic             evt_end,
  output logic             done,
  output logic [DUR_W-1:0] dur
);

  localparam logic [DUR_W-1:0] DUR_MAX = '1;
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  tmr_state_e       state_q, state_d;
  logic [DUR_W-1:0] dur_q, dur_d;
  logic             tmr_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    dur_d   = dur_q;
    done    = 1'b0;
    case (state_q)
      TMR_IDLE: begin
        if (evt_start) begin
          state_d = TMR_BUSY;
          dur_d   = DUR_ONE;
        end
      end
      TMR_BUSY: begin
        if (evt_end) begin
          done    = 1'b1;
          state_d = TMR_IDLE;
          dur_d   = '0;
        end else if (dur_q != DUR_MAX) begin
          dur_d = dur_q + DUR_ONE;
        end
      end
      default: begin
        state_d = TMR_IDLE;
        dur_d   = '0;
      end
    endcase
  end

  assign tmr_en = (state_q == TMR_BUSY) | evt_start;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      dur_q   <= '0;
    end else if (tmr_en) begin
      state_q <= state_d;
      dur_q   <= dur_d;
    end
  end

  assign dur = dur_q;

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TMR_BUSY && !evt_end && dur_q == DUR_MAX) |=> (dur_q == DUR_MAX));

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TMR_BUSY && !evt_end && evt_start && dur_q != DUR_MAX)
      |=> (state_q == TMR_BUSY && dur_q == $past(dur_q) + DUR_ONE));

  // R12
  idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TMR_IDLE && !evt_start) |=> (state_q == TMR_IDLE && dur_q == '0));

endmodule

// File: rtl/tdc_qual.sv
module tdc_qual #(
  parameter int THR_W    = 6,
  parameter int DUR_W    = 12,
  parameter int LO_SHIFT = 1,
  parameter int HI_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [DUR_W-1:0] dur,
  input  logic [THR_W-1:0] thr,
  input  logic             mult_sel,
  input  logic             qualify,
  input  logic             count_en,
  input  logic             freeze,
  output logic             hit
);

  logic [DUR_W-1:0] thr_wide;
  logic [DUR_W-1:0] thr_eff;
  logic             longer;
  logic             hit_d, hit_q;

  assign thr_wide = {{(DUR_W-THR_W){1'b0}}, thr};

  // Scaled threshold and strict comparison
  always_comb begin
    thr_eff = mult_sel ? (thr_wide << HI_SHIFT) : (thr_wide << LO_SHIFT);
    longer  = (dur > thr_eff);
    hit_d   = done & count_en & ~freeze & (~qualify | longer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;

  // R3
  equal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && qualify && dur == thr_eff) |=> !hit_q);

  // R8
  freeze_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && freeze) |=> !hit_q);

  // R10
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !count_en) |=> !hit_q);

endmodule

// File: rtl/tdc_counter.sv
module tdc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             freeze,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = hit & ~freeze;
    cnt_d  = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (cnt_q == $past(cnt_q)));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));

  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !freeze && cnt_q == '1) |=> (cnt_q == '0));

endmodule

// File: rtl/thr_dur_counter.sv
module thr_dur_counter #(
  parameter int THR_W    = 6,
  parameter int CNT_W    = 32,
  parameter int LO_SHIFT = 1,
  parameter int HI_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_start,
  input  logic             evt_end,
  input  logic [THR_W-1:0] thr,
  input  logic             mult_sel,
  input  logic             qualify,
  input  logic             count_en,
  input  logic             freeze,
  output logic [CNT_W-1:0] count
);

  localparam int THR_TOP = ((1 << THR_W) - 1) << HI_SHIFT;
  localparam int DUR_W   = $clog2(THR_TOP + 1) + 1;

  logic             rst_s_n;
  logic             done;
  logic [DUR_W-1:0] dur;
  logic             hit;

  tdc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  tdc_timer #(.DUR_W(DUR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .evt_start (evt_start),
    .evt_end   (evt_end),
    .done      (done),
    .dur       (dur)
  );

  tdc_qual #(
    .THR_W    (THR_W),
    .DUR_W    (DUR_W),
    .LO_SHIFT (LO_SHIFT),
    .HI_SHIFT (HI_SHIFT)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .done     (done),
    .dur      (dur),
    .thr      (thr),
    .mult_sel (mult_sel),
    .qualify  (qualify),
    .count_en (count_en),
    .freeze   (freeze),
    .hit      (hit)
  );

  tdc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .hit    (hit),
    .freeze (freeze),
    .count  (count)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (count == '0));

endmodule

// File: tb/thr_dur_counter_test.sv
module thr_dur_counter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_start, evt_end;
  logic [5:0]  thr;
  logic        mult_sel, qualify, count_en, freeze;
  logic [31:0] count;
  logic [3:0]  count_w4;

  int          n_chk  = 0;
  int          n_fail = 0;
  logic [31:0] exp_cnt = 0;

  always #4 clk = ~clk;

  thr_dur_counter uut (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_end(evt_end),
    .thr(thr), .mult_sel(mult_sel), .qualify(qualify), .count_en(count_en),
    .freeze(freeze), .count(count)
  );

  thr_dur_counter #(.CNT_W(4)) uut_w4 (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_end(evt_end),
    .thr(thr), .mult_sel(mult_sel), .qualify(qualify), .count_en(count_en),
    .freeze(freeze), .count(count_w4)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Start on the next edge, end d edges later, then wait for the increment edge.
  task automatic pulse_event(input int d);
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (d - 1) @(negedge clk);
    evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic timed(input string req, input int d, input bit counts);
    pulse_event(d);
    if (counts) exp_cnt++;
    check(req, count, exp_cnt);
    check({req, " narrow"}, {28'd0, count_w4}, {28'd0, exp_cnt[3:0]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    exp_cnt = 0;
    check("R1 reset value", count, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", count, 0);
  endtask

  task automatic t_scale_lo();  // R2 R3 R4 x2
    qualify = 1; mult_sel = 0; thr = 6'd5;
    timed("R3 equal 10", 10, 0);
    timed("R2 above 10", 11, 1);
    timed("R2 below 10", 4, 0);
    thr = 6'd0;
    timed("R2 dur1 thr0", 1, 1);
  endtask

  task automatic t_scale_hi();  // R4 x32
    qualify = 1; mult_sel = 1; thr = 6'd2;
    timed("R4 equal 64", 64, 0);
    timed("R4 above 64", 65, 1);
    mult_sel = 0;
    timed("R4 x2 same thr", 5, 1);
  endtask

  task automatic t_plain();  // R5
    qualify = 0; thr = 6'd63; mult_sel = 1;
    timed("R5 plain short", 1, 1);
    timed("R5 plain 3", 3, 1);
    qualify = 1;
  endtask

  task automatic t_latency();  // R6
    qualify = 0;
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (2) @(negedge clk);
    evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    check("R6 not on end edge", count, exp_cnt);
    @(negedge clk);
    exp_cnt++;
    check("R6 edge after end", count, exp_cnt);
    qualify = 1;
  endtask

  task automatic t_saturate();  // R7
    qualify = 1; mult_sel = 1; thr = 6'd63;
    timed("R7 saturated long", 4200, 1);
    timed("R7 at 2016 equal", 2016, 0);
  endtask

  task automatic t_freeze();  // R8
    qualify = 1; mult_sel = 0; thr = 6'd5;
    freeze = 1'b1;
    timed("R8 frozen event", 20, 0);
    freeze = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 no late count", count, exp_cnt);
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (19) @(negedge clk);
    evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0; freeze = 1'b1;
    @(negedge clk); freeze = 1'b0;
    @(negedge clk);
    check("R8 increment held", count, exp_cnt);
  endtask

  task automatic t_restart();  // R9
    qualify = 1; mult_sel = 0; thr = 6'd5;
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (4) @(negedge clk);
    evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (6) @(negedge clk);
    evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    @(negedge clk);
    exp_cnt++;
    check("R9 second start ignored", count, exp_cnt);
  endtask

  task automatic t_enable();  // R10
    qualify = 0; count_en = 1'b0;
    timed("R10 disabled", 3, 0);
    count_en = 1'b1;
    timed("R10 enabled again", 3, 1);
    qualify = 1;
  endtask

  task automatic t_stray_end();  // R12
    @(negedge clk); evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 stray end", count, exp_cnt);
  endtask

  task automatic t_reset_mid();  // R1
    qualify = 0;
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 abandoned event", count, 0);
    qualify = 1;
  endtask

  task automatic t_wrap();  // R11
    qualify = 0;
    while (exp_cnt[3:0] != 4'd15) timed("R11 fill", 1, 1);
    timed("R11 wrap", 1, 1);
    check("R11 narrow zero", {28'd0, count_w4}, 0);
    qualify = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    evt_start = 0; evt_end = 0; thr = 0; mult_sel = 0;
    qualify = 1; count_en = 1; freeze = 0; rst_n = 1'b0;
    do_reset();
    t_scale_lo();
    t_scale_hi();
    t_plain();
    t_latency();
    t_saturate();
    t_freeze();
    t_restart();
    t_enable();
    t_stray_end();
    t_reset_mid();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule